// File: doc/BRIEF.md
# Chunked Outgoing Staging Buffer Controller

This block manages a large byte staging area that sits between a packet framer and a burst-oriented link sender. The storage is split into equal, power-of-two sized chunks that are used in ring order. The framer offers one byte per cycle. The controller turns each accepted byte into a write strobe and address for an external single-port RAM. It also keeps the byte count of every closed chunk.

The sender side sees one chunk at a time: its index, its base address and its byte count, qualified by a valid signal. The sender frees the chunk with a one-cycle done pulse. Chunks are handed over strictly in the order they were filled.

When the sender is idle and nothing closed is waiting, a partly filled chunk is closed at once and queued, so data never sits unsent behind an idle link. When every chunk is closed and not yet freed, the chunk the writer needs is still held by the sender side. Incoming bytes are then dropped and a sticky overflow flag is raised. With the defaults (32 chunks of 2048 bytes) the block addresses 64 kB.

Top module: `stg_chunk_buf`

## Requirements
- R1: After reset `snd_valid_o` and `ovf_o` are low, `ram_we_o` is low while `wr_valid_i` is low, and the first accepted byte is written at address 0.
- R2: An accepted byte raises `ram_we_o` in the same cycle, with `ram_data_o` equal to `wr_data_i` and `ram_addr_o` equal to chunk index times CHUNK_BYTES plus the byte offset. Offsets within a chunk run 0, 1, 2, ... with no gaps.
- R3: A chunk that receives its CHUNK_BYTES-th byte closes with length CHUNK_BYTES. The next byte goes to offset 0 of the next chunk in ring order, and chunk NUM_CHUNKS-1 is followed by chunk 0.
- R4: In any cycle where the sender is idle (`snd_valid_o` low) and no closed chunk is waiting, a fill chunk that holds at least one byte is closed. This count includes a byte accepted in that same cycle. The chunk's length is its byte count, and the next byte goes to offset 0 of the next chunk.
- R5: While `snd_valid_o` is high and `snd_done_i` is low, `snd_valid_o`, `snd_chunk_o` and `snd_len_o` hold their values.
- R6: Chunks are offered in the order they were closed. After a done pulse `snd_valid_o` is low in the following cycle. If another chunk is waiting, it is offered one cycle later.
- R7: A chunk is offered only when its length is non-zero.
- R8: While all NUM_CHUNKS chunks are closed and not freed, a byte offered on `wr_valid_i` is dropped (`ram_we_o` low) and `ovf_o` is high from the next cycle on until it is cleared.
- R9: `ovf_clr_i` clears `ovf_o` in the next cycle. If a byte is dropped in the same cycle, the flag stays set.
- R10: `snd_done_i` has no effect while `snd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Framer offers a byte this cycle |
| wr_data_i | input | DATA_W (8) | Offered byte |
| ram_we_o | output | 1 | Write strobe to staging RAM |
| ram_addr_o | output | ADDR_W (16) | Staging RAM byte address |
| ram_data_o | output | DATA_W (8) | Staging RAM write data |
| snd_valid_o | output | 1 | A chunk is presented to the sender |
| snd_chunk_o | output | CHK_W (5) | Index of presented chunk |
| snd_base_o | output | ADDR_W (16) | Base byte address of presented chunk |
| snd_len_o | output | LEN_W (12) | Byte count of presented chunk |
| snd_done_i | input | 1 | One-cycle pulse: presented chunk is sent and free |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Clears the overflow flag |

## Verification
The assertions take for granted that the sender pulses `snd_done_i` for a single cycle and only while a chunk is presented. They also assume CHUNK_BYTES and NUM_CHUNKS are powers of two, so index arithmetic wraps naturally. The stimulus uses a sender model that raises done exactly once per offered chunk, after a hold time. The one exception is a single stray done pulse sent before any chunk exists, which exercises the rule that such a pulse is ignored. The sender model is held off while the ring is filled to overflow, so the closing order and the byte addresses stay fully predictable.

// File: rtl/stg_pkg.sv
package stg_pkg;
  typedef enum logic {
    SND_IDLE = 1'b0,
    SND_BUSY = 1'b1
  } snd_st_e;
endpackage

// File: rtl/stg_fill_ctrl.sv
module stg_fill_ctrl #(
  parameter int NUM_CHUNKS  = 32,
  parameter int CHUNK_BYTES = 2048,
  localparam int CHK_W  = $clog2(NUM_CHUNKS),
  localparam int OFF_W  = $clog2(CHUNK_BYTES),
  localparam int LEN_W  = OFF_W + 1,
  localparam int ADDR_W = CHK_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              ring_full_i,
  input  logic              can_close_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              close_o,
  output logic [CHK_W-1:0]  close_chk_o,
  output logic [LEN_W-1:0]  close_len_o
);
  logic [CHK_W-1:0] chk_q;
  logic [LEN_W-1:0] cnt_q, cnt_nxt;

  assign we_o    = wr_valid_i & ~ring_full_i;
  assign cnt_nxt = cnt_q + LEN_W'(we_o);
  assign addr_o  = {chk_q, cnt_q[OFF_W-1:0]};

  // close on full chunk, or early when the sender has nothing to do
  assign close_o     = (cnt_nxt == LEN_W'(CHUNK_BYTES)) |
                       (can_close_i & (cnt_nxt != '0));
  assign close_chk_o = chk_q;
  assign close_len_o = cnt_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q <= '0;
      cnt_q <= '0;
    end else if (close_o) begin
      chk_q <= chk_q + CHK_W'(1);
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/stg_send_ctrl.sv
module stg_send_ctrl
  import stg_pkg::*;
#(
  parameter int NUM_CHUNKS = 32,
  localparam int CHK_W = $clog2(NUM_CHUNKS),
  localparam int CNT_W = CHK_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             close_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic [CHK_W-1:0] rd_chk_o,
  output logic             ring_full_o,
  output logic             can_close_o
);
  snd_st_e          st_q;
  logic [CHK_W-1:0] rd_q;
  logic [CNT_W-1:0] pend_q;
  logic             start, done_acc;

  assign start    = (st_q == SND_IDLE) && (pend_q != '0);
  assign done_acc = (st_q == SND_BUSY) && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SND_IDLE;
      rd_q   <= '0;
      pend_q <= '0;
    end else begin
      if (start)         st_q <= SND_BUSY;
      else if (done_acc) st_q <= SND_IDLE;
      if (done_acc) rd_q <= rd_q + CHK_W'(1);
      pend_q <= pend_q + CNT_W'(close_i) - CNT_W'(done_acc);
    end
  end

  assign busy_o      = (st_q == SND_BUSY);
  assign rd_chk_o    = rd_q;
  assign ring_full_o = (pend_q == CNT_W'(NUM_CHUNKS));
  assign can_close_o = (st_q == SND_IDLE) && (pend_q == '0);
endmodule

// File: rtl/stg_len_table.sv
module stg_len_table #(
  parameter int NUM_CHUNKS  = 32,
  parameter int CHUNK_BYTES = 2048,
  localparam int CHK_W = $clog2(NUM_CHUNKS),
  localparam int LEN_W = $clog2(CHUNK_BYTES) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CHK_W-1:0] wr_idx_i,
  input  logic [LEN_W-1:0] wr_len_i,
  input  logic [CHK_W-1:0] rd_idx_i,
  output logic [LEN_W-1:0] rd_len_o
);
  logic [LEN_W-1:0] len_q [NUM_CHUNKS];

  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  len_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == CHK_W'(g))    len_q[g] <= wr_len_i;
    end
  end

  assign rd_len_o = len_q[rd_idx_i];
endmodule

// File: rtl/stg_chunk_buf.sv
module stg_chunk_buf #(
  parameter int NUM_CHUNKS  = 32,
  parameter int CHUNK_BYTES = 2048,
  parameter int DATA_W      = 8,
  localparam int CHK_W  = $clog2(NUM_CHUNKS),
  localparam int OFF_W  = $clog2(CHUNK_BYTES),
  localparam int LEN_W  = OFF_W + 1,
  localparam int ADDR_W = CHK_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_data_o,
  output logic              snd_valid_o,
  output logic [CHK_W-1:0]  snd_chunk_o,
  output logic [ADDR_W-1:0] snd_base_o,
  output logic [LEN_W-1:0]  snd_len_o,
  input  logic              snd_done_i,
  output logic              ovf_o,
  input  logic              ovf_clr_i
);
  logic             ring_full, can_close, close, busy;
  logic [CHK_W-1:0] close_chk, rd_chk;
  logic [LEN_W-1:0] close_len;
  logic             ovf_q;

  stg_fill_ctrl #(.NUM_CHUNKS(NUM_CHUNKS), .CHUNK_BYTES(CHUNK_BYTES)) u_fill (
    .clk_i, .rst_ni, .wr_valid_i,
    .ring_full_i(ring_full), .can_close_i(can_close),
    .we_o(ram_we_o), .addr_o(ram_addr_o),
    .close_o(close), .close_chk_o(close_chk), .close_len_o(close_len)
  );

  stg_send_ctrl #(.NUM_CHUNKS(NUM_CHUNKS)) u_send (
    .clk_i, .rst_ni, .close_i(close), .done_i(snd_done_i),
    .busy_o(busy), .rd_chk_o(rd_chk),
    .ring_full_o(ring_full), .can_close_o(can_close)
  );

  stg_len_table #(.NUM_CHUNKS(NUM_CHUNKS), .CHUNK_BYTES(CHUNK_BYTES)) u_len (
    .clk_i, .rst_ni, .wr_en_i(close), .wr_idx_i(close_chk),
    .wr_len_i(close_len), .rd_idx_i(rd_chk), .rd_len_o(snd_len_o)
  );

  // drop sets, clear next; set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ovf_q <= 1'b0;
    else if (wr_valid_i && !ram_we_o)  ovf_q <= 1'b1;
    else if (ovf_clr_i)                ovf_q <= 1'b0;
  end

  assign ram_data_o  = wr_data_i;
  assign snd_valid_o = busy;
  assign snd_chunk_o = rd_chk;
  assign snd_base_o  = {rd_chk, OFF_W'(0)};
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/stg_chunk_buf_chk.sv
module stg_chunk_buf_chk #(
  parameter int NUM_CHUNKS  = 32,
  parameter int CHUNK_BYTES = 2048,
  parameter int DATA_W      = 8,
  localparam int CHK_W = $clog2(NUM_CHUNKS),
  localparam int LEN_W = $clog2(CHUNK_BYTES) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic             ram_we_o,
  input logic             snd_valid_o,
  input logic [CHK_W-1:0] snd_chunk_o,
  input logic [LEN_W-1:0] snd_len_o,
  input logic             snd_done_i,
  input logic             ovf_o,
  input logic             ovf_clr_i
);
  logic [CHK_W-1:0] nxt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        nxt_q <= '0;
    else if (snd_valid_o && snd_done_i) nxt_q <= snd_chunk_o + CHK_W'(1);
  end

  // R2
  we_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> wr_valid_i);
  // R5
  snd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snd_valid_o && !snd_done_i) |=> (snd_valid_o && $stable(snd_chunk_o) && $stable(snd_len_o)));
  // R6
  snd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snd_valid_o && snd_done_i) |=> !snd_valid_o);
  // R6
  snd_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(snd_valid_o) |-> (snd_chunk_o == nxt_q));
  // R7
  snd_len_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snd_valid_o |-> (snd_len_o != '0));
  // R8
  drop_sets_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !ram_we_o) |=> ovf_o);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  // R9
  ovf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !(wr_valid_i && !ram_we_o)) |=> !ovf_o);
endmodule

bind stg_chunk_buf stg_chunk_buf_chk #(
  .NUM_CHUNKS(NUM_CHUNKS), .CHUNK_BYTES(CHUNK_BYTES), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_stg_chunk_buf.sv
module tb_stg_chunk_buf;
  localparam int NC = 4;
  localparam int CB = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       ram_we_o;
  logic [5:0] ram_addr_o;
  logic [7:0] ram_data_o;
  logic       snd_valid_o;
  logic [1:0] snd_chunk_o;
  logic [5:0] snd_base_o;
  logic [4:0] snd_len_o;
  logic       ovf_o;
  logic       ovf_clr_i = 1'b0;
  logic       mon_done = 1'b0, stray_done = 1'b0;
  logic       snd_en = 1'b0;

  int nvec = 0, nfail = 0;
  int q_chk[$], q_len[$];

  always #10 clk = ~clk;

  stg_chunk_buf #(.NUM_CHUNKS(NC), .CHUNK_BYTES(CB), .DATA_W(8)) dut (
    .clk_i(clk), .rst_ni, .wr_valid_i, .wr_data_i, .ram_we_o, .ram_addr_o,
    .ram_data_o, .snd_valid_o, .snd_chunk_o, .snd_base_o, .snd_len_o,
    .snd_done_i(mon_done | stray_done), .ovf_o, .ovf_clr_i
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic expect_chunk(input int c, input int l);
    q_chk.push_back(c);
    q_len.push_back(l);
  endtask

  // one byte per call; called at negedge, returns at next negedge
  task automatic wb(input int addr, input bit we, input string req);
    wr_valid_i = 1'b1;
    wr_data_i  = 8'(addr + 8'h5a);
    #1;
    check(ram_we_o == we, {req, " we"}, int'(ram_we_o), int'(we));
    if (we) begin
      check(ram_addr_o == 6'(addr), {req, " addr"}, int'(ram_addr_o), addr);
      check(ram_data_o == wr_data_i, "R2 data", int'(ram_data_o), int'(wr_data_i));
    end
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (q_chk.size() == 0 && !snd_valid_o && !mon_done) break;
    end
    check(q_chk.size() == 0, "R6 drain", q_chk.size(), 0);
  endtask

  // monitor: sender model, compares offered chunks against the queue
  initial begin
    bit seen = 1'b0;
    int hold = 0;
    int cap_c = 0, cap_l = 0;
    forever begin
      @(negedge clk);
      if (mon_done) begin
        mon_done = 1'b0;
        seen = 1'b0;
        check(!snd_valid_o, "R6 valid low after done", int'(snd_valid_o), 0);
      end else if (snd_valid_o && !seen) begin
        seen = 1'b1;
        hold = 0;
        cap_c = int'(snd_chunk_o);
        cap_l = int'(snd_len_o);
        check(snd_len_o != 0, "R7 len nonzero", cap_l, 1);
        check(snd_base_o == 6'(cap_c * CB), "R2 base", int'(snd_base_o), cap_c * CB);
        if (q_chk.size() == 0) begin
          check(1'b0, "R6 unexpected chunk", cap_c, -1);
        end else begin
          int ec, el;
          ec = q_chk.pop_front();
          el = q_len.pop_front();
          check(cap_c == ec, "R6 chunk order", cap_c, ec);
          check(cap_l == el, "R3/R4 chunk len", cap_l, el);
        end
      end else if (seen) begin
        check(snd_valid_o && int'(snd_chunk_o) == cap_c && int'(snd_len_o) == cap_l,
              "R5 offer stable", int'(snd_chunk_o), cap_c);
        if (snd_en) begin
          hold++;
          if (hold >= 2) mon_done = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    check(!snd_valid_o, "R1 valid", int'(snd_valid_o), 0);
    check(!ovf_o, "R1 ovf", int'(ovf_o), 0);
    check(!ram_we_o, "R1 we", int'(ram_we_o), 0);
    // R10: stray done with nothing offered
    stray_done = 1'b1;
    @(negedge clk);
    stray_done = 1'b0;
    @(negedge clk);
    check(!snd_valid_o, "R10 stray done", int'(snd_valid_o), 0);

    // sender held off; first byte closes chunk 0 at once (R4)
    expect_chunk(0, 1);
    wb(0, 1'b1, "R1 first byte");
    for (int i = 0; i < 4; i++) wb(CB + i, 1'b1, "R4 next chunk");
    expect_chunk(1, CB);
    for (int i = 4; i < CB; i++) wb(CB + i, 1'b1, "R2 fill");
    expect_chunk(2, CB);
    for (int i = 0; i < CB; i++) wb(2 * CB + i, 1'b1, "R3 advance");
    expect_chunk(3, CB);
    for (int i = 0; i < CB; i++) wb(3 * CB + i, 1'b1, "R3 advance");

    // R8: ring full, bytes dropped
    wb(0, 1'b0, "R8 drop");
    check(ovf_o, "R8 ovf set", int'(ovf_o), 1);
    repeat (3) @(negedge clk);
    check(ovf_o, "R8 ovf sticky", int'(ovf_o), 1);
    // R9: set wins over clear
    ovf_clr_i = 1'b1;
    wb(0, 1'b0, "R8 drop with clear");
    ovf_clr_i = 1'b0;
    check(ovf_o, "R9 set wins", int'(ovf_o), 1);
    ovf_clr_i = 1'b1;
    @(negedge clk);
    ovf_clr_i = 1'b0;
    check(!ovf_o, "R9 clear", int'(ovf_o), 0);

    // release sender; chunks 0..3 go out in order
    snd_en = 1'b1;
    drain();

    // wrap to chunk 0, partial close with idle sender
    snd_en = 1'b0;
    expect_chunk(0, 1);
    wb(0, 1'b1, "R3 wrap");
    for (int i = 0; i < 7; i++) wb(CB + i, 1'b1, "R4 behind busy");
    expect_chunk(1, 7);
    snd_en = 1'b1;
    drain();
    check(!ovf_o, "R9 stays clear", int'(ovf_o), 0);
    expect_chunk(2, 1);
    wb(2 * CB, 1'b1, "R4 after partial");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule